// File: doc/BRIEF.md
# Serial ADC Output Port Emulator

This block stands in for the digital side of a 12-bit serial converter. A host drives an active-low chip select and a serial clock. The block answers on a serial data line whose drive enable is a separate output, so the caller can build the tri-state pad or check the released intervals directly. The sample word arrives on a parallel input and is frozen at the moment chip select falls. Analog behaviour and nanosecond output delays are not modelled.

The host's chip select and serial clock are sampled on the block's own system clock, and their edges are found by comparing each sample with the one before. A frame is 16 serial clock falling edges long. The first four bits shifted out are zero, then the sample follows from its most significant bit down. After the sixteenth falling edge the line is released and a completion flag is raised. If chip select goes high before that, the frame is dropped and the flag stays low.

Top module: `ser_adc_port`

## Requirements
- R1: While reset is asserted and on the cycle after it, `sdo_oe`, `sdo` and `frame_done` are all 0.
- R2: The `sample` value is captured on the system clock edge that first sees `cs_n` low after a high value. Changes to `sample` after that edge have no effect on the bits of that frame.
- R3: One system clock after a chip select fall is seen, `sdo_oe` is 1 and `sdo` shows the first of four zero bits. Bits 0 to 3 of every frame are 0.
- R4: Each serial clock falling edge (`sclk` seen high, then low on the next system clock) advances the output by one bit, one system clock after the low sample. After fall n (1 to 15), `sdo` shows frame bit n. For n of 4 or more, frame bit n is `sample[15-n]`, so the word goes out most significant bit first.
- R5: If `cs_n` goes high before the sixteenth fall, `sdo_oe` drops one system clock later and `frame_done` stays 0.
- R6: On the sixteenth fall, `sdo_oe` drops and `frame_done` becomes 1. `frame_done` then holds, including across a later `cs_n` rise, until the next chip select fall clears it.
- R7: Serial clock falls after the sixteenth are ignored until the next chip select fall: `sdo_oe` stays 0 and `frame_done` stays 1.
- R8: `sdo` is 0 whenever `sdo_oe` is 0.
- R9: A chip select fall always restarts the bit count, so a frame that follows an aborted one delivers all 16 bits in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the host signals |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| sample | input | DATA_W | Parallel sample word to be sent |
| sdo | output | 1 | Serial data bit, 0 when the line is released |
| sdo_oe | output | 1 | Drive enable for the serial data line |
| frame_done | output | 1 | High after a complete 16-bit frame |

## Verification
The assertions check these rules on every cycle:
- The line is enabled right after a chip select fall.
- The line is released whenever chip select is high.
- A newly enabled line starts with a zero.
- The data bit holds steady between serial clock falls.
- The completion flag and the drive enable are never high together, and the flag persists.

Only the bench scenarios can show the exact bit order for particular sample words. They also show that sample changes after capture are ignored, that an aborted frame recovers, and that extra clocks after a full frame are ignored.

// File: rtl/ser_adc_port.sv
module ser_adc_port #(
  parameter int DATA_W     = 12,
  parameter int LEAD_ZEROS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [DATA_W-1:0] sample,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              frame_done
);
  localparam int FRAME = DATA_W + LEAD_ZEROS;
  localparam int CW    = $clog2(FRAME);

  logic             cs_q, sclk_q;
  logic [FRAME-1:0] shreg;
  logic [CW-1:0]    cnt;
  logic             oe_q, done_q;

  wire cs_fall   = cs_q & ~cs_n;
  wire sclk_fall = sclk_q & ~sclk;
  wire last_bit  = (cnt == CW'(FRAME - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
      shreg  <= '0;
      cnt    <= '0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (cs_fall) begin
        shreg  <= {{LEAD_ZEROS{1'b0}}, sample};
        cnt    <= '0;
        oe_q   <= 1'b1;
        done_q <= 1'b0;
      end else if (cs_n) begin
        oe_q <= 1'b0;
      end else if (oe_q && sclk_fall) begin
        if (last_bit) begin
          oe_q   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt   <= CW'(cnt + 1'b1);
          shreg <= {shreg[FRAME-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo_oe     = oe_q;
  assign sdo        = oe_q & shreg[FRAME-1];
  assign frame_done = done_q;

  a_r3_enable_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && !cs_n) |=> sdo_oe);

  a_r5_release_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo_oe);

  a_r3_first_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);

  a_r4_hold_between_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && !cs_n && !cs_q && !(sclk_q && !sclk)) |=> $stable(sdo));

  a_r6_done_excludes_enable: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !sdo_oe);

  a_r7_done_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !(cs_q && !cs_n)) |=> (frame_done && !sdo_oe));
endmodule

// File: tb/sim_ser_adc_port.sv
module sim_ser_adc_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic [11:0] sample = '0;
  logic sdo, sdo_oe, frame_done;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ser_adc_port u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
                   .sample(sample), .sdo(sdo), .sdo_oe(sdo_oe),
                   .frame_done(frame_done));

  localparam logic [11:0] VEC [0:5] = '{12'h000, 12'hFFF, 12'hA5C,
                                        12'h5A3, 12'h801, 12'h001};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic fall();
    sclk = 1'b1; tick();
    sclk = 1'b0; tick();
  endtask

  function automatic logic exp_bit(input logic [11:0] w, input int n);
    return (n < 4) ? 1'b0 : w[15-n];
  endfunction

  task automatic run_frame(input logic [11:0] w, input int nf, input logic [11:0] late);
    sample = w;
    cs_n = 1'b0; tick();
    sample = late;
    chk("R3 oe after select", sdo_oe, 1);
    chk("R3 first zero", sdo, 0);
    for (int n = 1; n <= nf; n++) begin
      fall();
      if (n < 16) begin
        chk("R4 oe mid frame", sdo_oe, 1);
        chk("R4 bit value", sdo, exp_bit(w, n));
      end else begin
        chk("R6 oe after last fall", sdo_oe, 0);
        chk("R6 done after last fall", frame_done, 1);
        chk("R8 sdo low when released", sdo, 0);
      end
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 oe in reset", sdo_oe, 0);
    chk("R1 sdo in reset", sdo, 0);
    chk("R1 done in reset", frame_done, 0);
    rst_n = 1'b1; tick();
    chk("R1 oe after reset", sdo_oe, 0);
    chk("R1 done after reset", frame_done, 0);

    foreach (VEC[i]) begin
      run_frame(VEC[i], 16, VEC[i]);
      cs_n = 1'b1; tick();
      chk("R6 done held after deselect", frame_done, 1);
      chk("R8 released sdo", sdo, 0);
    end

    run_frame(12'h3C5, 16, 12'hFFF);
    chk("R2 done with late change", frame_done, 1);
    for (int k = 0; k < 3; k++) begin
      fall();
      chk("R7 extra fall oe", sdo_oe, 0);
      chk("R7 extra fall done", frame_done, 1);
      chk("R7 extra fall sdo", sdo, 0);
    end
    cs_n = 1'b1; tick();

    run_frame(12'hBEE, 7, 12'hBEE);
    chk("R6 done cleared by select", frame_done, 0);
    cs_n = 1'b1; tick();
    chk("R5 abort oe", sdo_oe, 0);
    chk("R5 abort done", frame_done, 0);
    chk("R8 abort sdo", sdo, 0);
    for (int k = 0; k < 2; k++) begin
      fall();
      chk("R5 sclk while deselected", sdo_oe, 0);
    end

    run_frame(12'h6D9, 16, 12'h000);
    chk("R9 restart completes", frame_done, 1);
    cs_n = 1'b1; tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule